// File: doc/BRIEF.md
# DRAM Channel Select Logic

This block decides which of two DRAM controllers, channel 0 or channel 1, serves a physical system address. It takes the address, a flag saying that an earlier range check placed the address in the high controller-select range, a three-bit node interleave field, and the fields of a controller-select configuration word. From these it produces a single channel bit.

The choice follows a fixed priority order. Ganged operation comes first and always picks channel 0. A high-range hit comes next and returns the configured high-range channel. Channel interleaving follows. It can use a 64-byte line bit, a parity hash of five upper address bits, or a granularity that follows the node interleave field. If interleave is off and the high range is enabled, the block returns the opposite of the high-range channel. Any other case falls back to channel 0.

The decision is available combinationally. It is also captured in a one-stage register with a valid flag, for callers that need a registered result.

Top module: `chsel_top`

## Requirements
- R1: When `cfg_ganged` is 1, `comb_chan` is 0 whatever the other inputs are.
- R2: When `cfg_ganged` is 0 and `hi_hit` is 1, `comb_chan` equals `cfg_hi_chan`. This holds even when `cfg_ilv_en` is 1.
- R3: When `cfg_ganged`=0, `hi_hit`=0, `cfg_ilv_en`=1 and `cfg_ilv_mode`=2'b00, `comb_chan` equals `sys_addr[6]`.
- R4: Under the same conditions with `cfg_ilv_mode[1]`=1, `comb_chan` equals the XOR of `sys_addr[20:16]`, further XORed with `sys_addr[9]` when `cfg_ilv_mode[0]`=1 and with `sys_addr[6]` when it is 0.
- R5: Under the same conditions with `cfg_ilv_mode`=2'b01, `comb_chan` is chosen by `node_ilv`. It is `sys_addr[15]` if `node_ilv[2]` is set. Otherwise it is `sys_addr[14]` if `node_ilv[1]` is set, otherwise `sys_addr[13]` if `node_ilv[0]` is set, and `sys_addr[12]` if none is set.
- R6: When `cfg_ganged`=0, `hi_hit`=0, `cfg_ilv_en`=0 and `cfg_hi_en`=1, `comb_chan` is the inverse of `cfg_hi_chan`.
- R7: In every case not covered above, `comb_chan` is 0.
- R8: When `in_valid` is 1 at a rising clock edge with `rst` low, then after that edge `out_valid` is 1 and `out_chan` holds the `comb_chan` value that was present at the edge.
- R9: When `in_valid` is 0 at a rising clock edge with `rst` low, then after that edge `out_valid` is 0 and `out_chan` keeps its previous value.
- R10: A rising edge with `rst`=1 sets both `out_valid` and `out_chan` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present; capture the decision |
| sys_addr | input | 48 | Physical system address |
| hi_hit | input | 1 | Address lies in the high controller-select range |
| node_ilv | input | 3 | Node interleave enable field |
| cfg_ganged | input | 1 | Both controllers operate as one (ganged) |
| cfg_hi_en | input | 1 | High controller-select range enabled |
| cfg_ilv_en | input | 1 | Channel interleave enabled |
| cfg_ilv_mode | input | 2 | Interleave address mode |
| cfg_hi_chan | input | 1 | Channel that serves the high range |
| comb_chan | output | 1 | Combinational channel decision |
| out_valid | output | 1 | Registered decision valid |
| out_chan | output | 1 | Registered channel decision |

## Verification
The assertions treat the configuration fields and `hi_hit` as settled at each sampling edge. They rely on the range check upstream to raise `hi_hit` only when it has meaning; they do not cross-check it against `cfg_hi_en`. The stimulus changes every input only on the falling edge, so the rising edge that samples the inputs always sees stable values. The sweep covers every combination of configuration, `hi_hit` and `node_ilv`, including `hi_hit` together with interleave, over a set of computed addresses. A second sweep covers all 32 values of the hashed bits with both line bits.

// File: rtl/chsel_pkg.sv
package chsel_pkg;

    typedef struct packed {
        logic       ganged;
        logic       hi_en;
        logic       ilv_en;
        logic [1:0] ilv_mode;
        logic       hi_chan;
    } sel_cfg_t;

    typedef enum logic [2:0] {
        RULE_GANG    = 3'd0,
        RULE_HIHIT   = 3'd1,
        RULE_LINE    = 3'd2,
        RULE_HASH    = 3'd3,
        RULE_NODE    = 3'd4,
        RULE_HIOTHER = 3'd5,
        RULE_ZERO    = 3'd6
    } sel_rule_t;

    // Priority walk over the configuration; address bits are not needed here.
    function automatic sel_rule_t classify(input sel_cfg_t c, input logic hit);
        sel_rule_t r;
        if (c.ganged)               r = RULE_GANG;
        else if (hit)               r = RULE_HIHIT;
        else if (c.ilv_en) begin
            if (c.ilv_mode == 2'b00) r = RULE_LINE;
            else if (c.ilv_mode[1]) r = RULE_HASH;
            else                    r = RULE_NODE;
        end
        else if (c.hi_en)           r = RULE_HIOTHER;
        else                        r = RULE_ZERO;
        return r;
    endfunction

endpackage

// File: rtl/chsel_rule.sv
module chsel_rule
    import chsel_pkg::*;
(
    input  sel_cfg_t  cfg,
    input  logic      hi_hit,
    output sel_rule_t rule
);
    always_comb begin
        rule = classify(cfg, hi_hit);
    end
endmodule

// File: rtl/chsel_bit.sv
module chsel_bit
    import chsel_pkg::*;
#(
    parameter int ADDR_W    = 48,
    parameter int LINE_BIT  = 6,
    parameter int ALT_BIT   = 9,
    parameter int HASH_LO   = 16,
    parameter int HASH_W    = 5,
    parameter int NODE_BASE = 12,
    parameter int NODE_W    = 3
) (
    input  sel_rule_t         rule,
    input  sel_cfg_t          cfg,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NODE_W-1:0] node_ilv,
    output logic              chan
);
    localparam int HASH_HI = HASH_LO + HASH_W - 1;

    logic hash_par;
    logic hash_chan;
    logic node_chan;

    assign hash_par  = ^addr[HASH_HI:HASH_LO];
    assign hash_chan = hash_par ^ (cfg.ilv_mode[0] ? addr[ALT_BIT] : addr[LINE_BIT]);

    // Highest set bit of the node field picks the granularity; loop order gives priority.
    always_comb begin
        node_chan = addr[NODE_BASE];
        for (int i = 0; i < NODE_W; i++) begin
            if (node_ilv[i]) node_chan = addr[NODE_BASE + 1 + i];
        end
    end

    always_comb begin
        unique case (rule)
            RULE_HIHIT:   chan = cfg.hi_chan;
            RULE_LINE:    chan = addr[LINE_BIT];
            RULE_HASH:    chan = hash_chan;
            RULE_NODE:    chan = node_chan;
            RULE_HIOTHER: chan = ~cfg.hi_chan;
            default:      chan = 1'b0;
        endcase
    end
endmodule

// File: rtl/chsel_stage.sv
module chsel_stage (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic d_chan,
    output logic out_valid,
    output logic out_chan
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_chan  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_chan <= d_chan;
        end
    end

    AST_CAPTURE_NEXT: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_valid && out_chan == $past(d_chan))); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_chan))); // R9
endmodule

// File: rtl/chsel_top.sv
module chsel_top
    import chsel_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int NODE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] sys_addr,
    input  logic              hi_hit,
    input  logic [NODE_W-1:0] node_ilv,
    input  logic              cfg_ganged,
    input  logic              cfg_hi_en,
    input  logic              cfg_ilv_en,
    input  logic [1:0]        cfg_ilv_mode,
    input  logic              cfg_hi_chan,
    output logic              comb_chan,
    output logic              out_valid,
    output logic              out_chan
);
    sel_cfg_t  cfg;
    sel_rule_t rule;
    logic      unused_addr;

    assign cfg = '{ganged: cfg_ganged, hi_en: cfg_hi_en, ilv_en: cfg_ilv_en,
                   ilv_mode: cfg_ilv_mode, hi_chan: cfg_hi_chan};
    assign unused_addr = ^sys_addr;

    chsel_rule u_rule (.cfg(cfg), .hi_hit(hi_hit), .rule(rule));

    chsel_bit #(.ADDR_W(ADDR_W), .NODE_W(NODE_W)) u_bit (
        .rule(rule), .cfg(cfg), .addr(sys_addr), .node_ilv(node_ilv), .chan(comb_chan)
    );

    chsel_stage u_stage (
        .clk(clk), .rst(rst), .in_valid(in_valid), .d_chan(comb_chan),
        .out_valid(out_valid), .out_chan(out_chan)
    );

    AST_GANGED_ZERO: assert property (@(posedge clk) disable iff (rst)
        cfg_ganged |-> !comb_chan); // R1
    AST_HIHIT_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (!cfg_ganged && hi_hit) |-> (comb_chan == cfg_hi_chan)); // R2
    AST_HIOTHER_INV: assert property (@(posedge clk) disable iff (rst)
        (!cfg_ganged && !hi_hit && !cfg_ilv_en && cfg_hi_en) |-> (comb_chan != cfg_hi_chan)); // R6
    AST_FALLBACK_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!cfg_ganged && !hi_hit && !cfg_ilv_en && !cfg_hi_en) |-> !comb_chan); // R7
endmodule

// File: tb/chsel_top_tb.sv
module chsel_top_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [47:0] sys_addr = '0;
    logic        hi_hit = 1'b0;
    logic [2:0]  node_ilv = '0;
    logic        cfg_ganged = 1'b0, cfg_hi_en = 1'b0, cfg_ilv_en = 1'b0, cfg_hi_chan = 1'b0;
    logic [1:0]  cfg_ilv_mode = '0;
    logic        comb_chan, out_valid, out_chan;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chsel_top u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .sys_addr(sys_addr), .hi_hit(hi_hit),
        .node_ilv(node_ilv), .cfg_ganged(cfg_ganged), .cfg_hi_en(cfg_hi_en),
        .cfg_ilv_en(cfg_ilv_en), .cfg_ilv_mode(cfg_ilv_mode), .cfg_hi_chan(cfg_hi_chan),
        .comb_chan(comb_chan), .out_valid(out_valid), .out_chan(out_chan)
    );

    // Reference computed from the requirements; tag names the rule used.
    function automatic logic ref_chan(output string tag);
        logic p;
        if (cfg_ganged) begin tag = "R1"; return 1'b0; end
        if (hi_hit) begin tag = "R2"; return cfg_hi_chan; end
        if (cfg_ilv_en) begin
            if (cfg_ilv_mode == 2'b00) begin tag = "R3"; return sys_addr[6]; end
            if (cfg_ilv_mode[1]) begin
                tag = "R4";
                p = sys_addr[16] ^ sys_addr[17] ^ sys_addr[18] ^ sys_addr[19] ^ sys_addr[20];
                return p ^ (cfg_ilv_mode[0] ? sys_addr[9] : sys_addr[6]);
            end
            tag = "R5";
            if (node_ilv[2]) return sys_addr[15];
            if (node_ilv[1]) return sys_addr[14];
            if (node_ilv[0]) return sys_addr[13];
            return sys_addr[12];
        end
        if (cfg_hi_en) begin tag = "R6"; return ~cfg_hi_chan; end
        tag = "R7";
        return 1'b0;
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b (addr=%h cfg=%b%b%b%b%b hit=%b node=%b)",
                     tag, act, exp, sys_addr, cfg_ganged, cfg_hi_en, cfg_ilv_en,
                     cfg_ilv_mode, cfg_hi_chan, hi_hit, node_ilv);
        end
    endtask

    // Drive at falling edge, check combinational result, then the registered one.
    task automatic apply_and_check();
        string tag;
        logic  e;
        e = ref_chan(tag);
        #1;
        check(tag, comb_chan, e);
        @(posedge clk); #1;
        check("R8 valid", out_valid, 1'b1);
        check("R8 data", out_chan, e);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R10 valid", out_valid, 1'b0);
        check("R10 data", out_chan, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        in_valid = 1'b1;

        // Full sweep of configuration, hit flag and node field over computed addresses.
        for (int c = 0; c < 64; c++) begin
            for (int nd = 0; nd < 8; nd++) begin
                for (int k = 0; k < 6; k++) begin
                    logic [63:0] h;
                    h = (64'(k + c * 7 + nd * 3 + 1)) * 64'h9E3779B97F4A7C15;
                    sys_addr     = (k == 0) ? 48'h0 : (k == 5) ? 48'hFFFF_FFFF_FFFF : h[55:8];
                    {cfg_ganged, cfg_hi_en, cfg_ilv_en, cfg_ilv_mode, cfg_hi_chan} = c[5:0];
                    hi_hit       = c[0] ^ nd[0] ^ k[0];
                    node_ilv     = nd[2:0];
                    apply_and_check();
                end
            end
        end

        // Hash sweep: every value of the hashed field with both line bits, both modes (R4).
        cfg_ganged = 1'b0; hi_hit = 1'b0; cfg_ilv_en = 1'b1; cfg_hi_en = 1'b1; node_ilv = 3'b101;
        for (int m = 2; m < 4; m++) begin
            for (int v = 0; v < 128; v++) begin
                cfg_ilv_mode = m[1:0];
                cfg_hi_chan  = v[0];
                sys_addr = '0;
                sys_addr[20:16] = v[4:0];
                sys_addr[6] = v[5];
                sys_addr[9] = v[6];
                apply_and_check();
            end
        end

        // Hit together with interleave: high-range rule wins (R2).
        cfg_ilv_en = 1'b1; cfg_ilv_mode = 2'b00; hi_hit = 1'b1; cfg_hi_chan = 1'b1;
        sys_addr = 48'h0;
        #1 check("R2 priority", comb_chan, 1'b1);
        @(posedge clk); #1;
        check("R8 data", out_chan, 1'b1);

        // Idle cycle: output holds even though the decision changes (R9).
        @(negedge clk);
        in_valid = 1'b0; cfg_hi_chan = 1'b0;
        @(posedge clk); #1;
        check("R9 valid", out_valid, 1'b0);
        check("R9 hold", out_chan, 1'b1);

        // Mid-run reset clears a stored 1 (R10).
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b1; cfg_hi_chan = 1'b1;
        @(posedge clk); #1;
        check("R10 valid", out_valid, 1'b0);
        check("R10 data", out_chan, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule